// File: doc/BRIEF.md
# Ring Polarity Period Timer

This block watches two comparator outputs on a telephone line interface. Channel A is high while its sensed level sits below the reference. Channel B is high while its sensed level sits above the reference. Both inputs are brought into the 32.768 kHz clock domain and then held as two status bits. The block raises a one-cycle event when the channel A status drops and another when the channel B status rises.

Each channel B event restarts a timer that counts in ticks of 1/2048 s, which is the clock divided by 16. The timer stops at 255. When a B event closes a B, then A, then B sequence, the elapsed tick count is loaded into an 8-bit period register. The register reads 255 after reset, after the first B event, and after any B event that arrives once the timer has stopped at its ceiling. Host software reads this register to qualify ringing cadence.

Top module: `ring_period_timer`

## Requirements
- R1: `status_o[1]` follows `cmp_a_i` and `status_o[0]` follows `cmp_b_i`. Each appears two rising clock edges after the input changes.
- R2: `irq_a_o` is high for exactly one cycle each time `status_o[1]` goes from 1 to 0. It stays low when that bit rises.
- R3: `irq_b_o` is high for exactly one cycle each time `status_o[0]` goes from 0 to 1. It stays low when that bit falls.
- R4: While `rst_ni` is low, `period_o` is 255, `status_o` is 0 and both interrupt outputs are 0.
- R5: The first `irq_b_o` pulse after reset writes 255 to `period_o`, even if `irq_a_o` pulses came before it.
- R6: Let N be the number of clock cycles between two rising edges of `cmp_b_i`. If at least one A event falls between them, the second B event writes min(floor((N-1)/16), 255) to `period_o`.
- R7: A B event with no A event since the previous B event leaves `period_o` unchanged.
- R8: A B event writes 255 once the tick count since the previous B event has reached 255, that is when N-1 >= 4080. This holds even if an A event came in between.
- R9: `period_o` changes only on the clock edge that follows an `irq_b_o` pulse.
- R10: A B event that wrote 255 because of a timeout still starts a new sequence. A following A event and B event then load a measured value again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 32.768 kHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_a_i | input | 1 | Comparator A; high while the sensed level is below the reference |
| cmp_b_i | input | 1 | Comparator B; high while the sensed level is above the reference |
| irq_a_o | output | 1 | One-cycle pulse on a falling edge of the A status |
| irq_b_o | output | 1 | One-cycle pulse on a rising edge of the B status |
| period_o | output | 8 | Period register, in units of 1/2048 s |
| status_o | output | 2 | Synchronised status: bit 1 is channel A, bit 0 is channel B |

## Verification
The hardest case to reach is the timeout boundary. An A event must fall between two B events, and the gap between them must be long enough for the tick counter to reach its ceiling. That needs thousands of clock cycles of quiet inputs, so the stimulus table places gaps on either side of the 4081-cycle edge. Every table row also begins with a B event that has no A event before it, so the hold rule (R7) is checked between measured rows.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
   localparam int NUM_CH = 2;
   localparam int CH_B   = 0;
   localparam int CH_A   = 1;

   function automatic int unsigned clog2_min1(input int unsigned v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction
endpackage

// File: rtl/rpt_sync.sv
module rpt_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      assert (STAGES >= 1) else $fatal(1, "rpt_sync: STAGES must be at least 1");
      assert (WIDTH >= 1) else $fatal(1, "rpt_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rpt_edge.sv
module rpt_edge #(
   parameter int WIDTH = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= lvl_i;
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      assign rise_o[g] =  lvl_i[g] & ~prev_q[g];
      assign fall_o[g] = ~lvl_i[g] &  prev_q[g];
   end
endmodule

// File: rtl/rpt_tick.sv
module rpt_tick #(
   parameter int DIV = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   output logic tick_o
);
   initial begin
      assert (DIV >= 1) else $fatal(1, "rpt_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick_o = ~restart_i;
   end else begin : g_count
      localparam int DW = rpt_pkg::clog2_min1(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)              div_q <= '0;
         else if (restart_i)       div_q <= '0;
         else if (div_q == LAST)   div_q <= '0;
         else                      div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST) & ~restart_i;
   end
endmodule

// File: rtl/rpt_period.sv
module rpt_period #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         ev_a_i,
   input  logic         ev_b_i,
   input  logic         tick_i,
   output logic [W-1:0] period_o
);
   localparam logic [W-1:0] CEIL = '1;

   initial begin
      assert (W >= 2) else $fatal(1, "rpt_period: W must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] period_q;
   logic         armed_q;
   logic         mid_q;
   logic         timed_out;

   assign timed_out = (cnt_q == CEIL);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         period_q <= CEIL;
         armed_q  <= 1'b0;
         mid_q    <= 1'b0;
      end else if (ev_b_i) begin
         if (!armed_q || timed_out) period_q <= CEIL;
         else if (mid_q)            period_q <= cnt_q;
         cnt_q   <= '0;
         armed_q <= 1'b1;
         mid_q   <= 1'b0;
      end else begin
         if (ev_a_i && armed_q)     mid_q <= 1'b1;
         if (tick_i && !timed_out)  cnt_q <= cnt_q + 1'b1;
      end
   end

   assign period_o = period_q;
endmodule

// File: rtl/ring_period_timer.sv
module ring_period_timer #(
   parameter int SYNC_STAGES = 2,
   parameter int TICK_DIV    = 16,
   parameter int PERIOD_W    = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cmp_a_i,
   input  logic                cmp_b_i,
   output logic                irq_a_o,
   output logic                irq_b_o,
   output logic [PERIOD_W-1:0] period_o,
   output logic [1:0]          status_o
);
   import rpt_pkg::*;

   logic [NUM_CH-1:0] raw;
   logic [NUM_CH-1:0] lvl;
   logic [NUM_CH-1:0] rise;
   logic [NUM_CH-1:0] fall;
   logic              tick;

   assign raw[CH_A] = cmp_a_i;
   assign raw[CH_B] = cmp_b_i;

   rpt_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) i_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(lvl)
   );

   rpt_edge #(.WIDTH(NUM_CH)) i_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .rise_o(rise), .fall_o(fall)
   );

   rpt_tick #(.DIV(TICK_DIV)) i_tick (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(rise[CH_B]), .tick_o(tick)
   );

   rpt_period #(.W(PERIOD_W)) i_period (
      .clk_i(clk_i), .rst_ni(rst_ni), .ev_a_i(fall[CH_A]), .ev_b_i(rise[CH_B]),
      .tick_i(tick), .period_o(period_o)
   );

   assign irq_a_o  = fall[CH_A];
   assign irq_b_o  = rise[CH_B];
   assign status_o = {lvl[CH_A], lvl[CH_B]};
endmodule

// File: rtl/rpt_checker.sv
module rpt_checker #(
   parameter int W = 8
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         cmp_a_i,
   input logic         cmp_b_i,
   input logic         irq_a_o,
   input logic         irq_b_o,
   input logic [W-1:0] period_o,
   input logic [1:0]   status_o
);
   logic [1:0] since_rst_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 since_rst_q <= '0;
      else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 1'b1;
   end

   // R1
   a_r1_status_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst_q >= 2'd2) |-> (status_o == {$past(cmp_a_i, 2), $past(cmp_b_i, 2)}));

   a_r2_a_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_a_o |=> !irq_a_o);

   a_r2_a_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_a_o |-> (!status_o[1] && $past(status_o[1])));

   a_r3_b_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_b_o |=> !irq_b_o);

   a_r3_b_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_b_o |-> (status_o[0] && !$past(status_o[0])));

   a_r9_period_only_on_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_b_o |=> $stable(period_o));
endmodule

bind ring_period_timer rpt_checker #(.W(PERIOD_W)) i_rpt_checker (
   .clk_i(clk_i), .rst_ni(rst_ni), .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
   .irq_a_o(irq_a_o), .irq_b_o(irq_b_o), .period_o(period_o), .status_o(status_o)
);

// File: tb/test_ring_period_timer.sv
module test_ring_period_timer;
   localparam time CLK_PERIOD = 20ns;
   localparam int  NVEC       = 9;
   localparam int  WATCHDOG   = 150000;

   // each row: {gap in cycles between B rises, expected period}
   localparam int unsigned VEC [NVEC][2] = '{
      '{17, 1}, '{16, 0}, '{12, 0}, '{33, 2}, '{100, 6},
      '{1000, 62}, '{4080, 254}, '{4081, 255}, '{6000, 255}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_a = 1'b0;
   logic       cmp_b = 1'b0;
   logic       irq_a, irq_b;
   logic [7:0] period;
   logic [1:0] status;

   int n_run  = 0;
   int n_fail = 0;
   int prev_period;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_period_timer i_ring_period_timer (
      .clk_i(clk), .rst_ni(rst_n), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
      .irq_a_o(irq_a), .irq_b_o(irq_b), .period_o(period), .status_o(status)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // B event with no A before it (hold), then A event, then B event after gap
   task automatic run_seq(input int gap, input int exp, input string req);
      cmp_b = 1'b0;
      step(4);
      cmp_b = 1'b1;
      step(4);
      check("R7 hold", period, prev_period);
      cmp_b = 1'b0;
      cmp_a = 1'b1;
      step(4);
      cmp_a = 1'b0;
      step(gap - 8);
      cmp_b = 1'b1;
      step(6);
      check(req, period, exp);
      prev_period = exp;
   endtask

   initial begin
      step(3);
      // R4 reset state
      check("R4 period", period, 255);
      check("R4 status", status, 0);
      check("R4 irq", {irq_a, irq_b}, 0);
      rst_n = 1'b1;
      step(2);

      // R1/R2: A status latency, no irq on rise, pulse on fall
      cmp_a = 1'b1;
      step(1);
      check("R1 latency", status[1], 0);
      step(1);
      check("R1 status a", status[1], 1);
      check("R2 no irq on rise", irq_a, 0);
      step(2);
      cmp_a = 1'b0;
      step(2);
      check("R2 irq on fall", irq_a, 1);
      step(1);
      check("R2 single pulse", irq_a, 0);
      step(2);

      // R3/R5: first B event after reset writes 255 despite prior A event
      cmp_b = 1'b1;
      step(2);
      check("R3 irq on rise", irq_b, 1);
      check("R1 status b", status[0], 1);
      step(1);
      check("R3 single pulse", irq_b, 0);
      step(1);
      check("R5 first b", period, 255);
      prev_period = 255;
      cmp_b = 1'b0;
      step(2);
      check("R3 no irq on fall", irq_b, 0);
      check("R1 status b low", status[0], 0);

      // R6/R8 table walk
      for (int i = 0; i < NVEC; i++) begin
         run_seq(int'(VEC[i][0]), int'(VEC[i][1]),
                 (VEC[i][0] >= 4081) ? "R8 timeout" : "R6 measured");
      end

      // R10: after a timeout, the next sequence measures again
      run_seq(40, 2, "R10 after timeout");

      // R4: reset mid-run restores the preset
      rst_n = 1'b0;
      step(1);
      check("R4 reset again", period, 255);
      check("R4 status again", status, 0);
      rst_n = 1'b1;
      step(2);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule